// File: doc/BRIEF.md
# Multiplexed DRAM pattern tester

This block exercises a single-bit dynamic RAM that takes its address in two halves on one shared bus: a row value latched by the falling row strobe, then a column value latched by the falling column strobe. With the default parameters the bus is 9 bits wide, so the device holds 256K cells seen as 512 rows by 512 columns. The tester visits every cell in ascending linear order, first writing a data pattern to all of them and then reading every cell back and comparing it. The patterns come in a fixed order: all zeros, all ones, a checkerboard whose bit follows the address LSB, and the inverse checkerboard. After the fourth pattern the sequence starts over and repeats for as long as the block runs.

Refresh and power-up wake-up cycles belong to a separate sequencer. Before each access the tester looks at a grant from that sequencer, and it waits while the grant is low. A busy output tells the sequencer when the tester is between the start of an access and the end of its precharge. Three indicator outputs show the state: running (not stalled on the grant), pass (the last pattern read back with no mismatch), and fail (held from the first mismatch until reset). A saturating mismatch count and the linear address of the first failing cell are also brought out.

The strobe timings are counted in clocks and set by parameters: row-to-column delay, column strobe width (which is also the read sample point), and minimum precharge.

Top module: `dram_pattern_tester`

## Requirements
- R1: Each access drives the row half `lin[2*ROW_W-1:ROW_W]` on `dram_addr` and lowers `dram_ras_n`. Exactly T_RCD clocks later it drives the column half `lin[ROW_W-1:0]` and lowers `dram_cas_n`, and it holds that address for as long as CAS stays low. Within a pass the linear address `lin` runs from 0 up to 2^(2*ROW_W)-1 with no gaps.
- R2: CAS stays low for exactly T_CAS clocks. `dram_ras_n` and `dram_cas_n` then rise in the same clock, and both stay high for at least T_PRE clocks before RAS falls again.
- R3: In a write pass `dram_we_n` is low from the fall of RAS, so it is already low when CAS falls. In a read pass it stays high. It does not change while CAS is low.
- R4: On a read, `dram_dout` is sampled T_CAS clocks after CAS falls and compared with the expected bit of the current pattern.
- R5: The pattern index takes the values 0, 1, 2, 3 in that order, then wraps to 0. The expected bit is 0 for pattern 0 and 1 for pattern 1. For pattern 2 it is `lin[0]`, and for pattern 3 it is the inverse of `lin[0]`. Each pattern has one full write pass that drives the expected bit on `dram_din`, followed by one full read pass.
- R6: A new access starts only if `tst_gnt` was high at the clock edge that starts it. `tst_busy` is high from the start of an access through the end of its precharge. The grant is not looked at in the middle of an access.
- R7: `led_run` is low after a clock edge at which the tester was idle with `tst_gnt` low, and high after any other edge.
- R8: At the end of each read pass, `led_pass` is set to 1 if that pass had no mismatch and to 0 if it had one.
- R9: `led_fail` goes high on the first mismatch and stays high until reset.
- R10: `err_count` goes up by one on each mismatch and holds at its all-ones value once it reaches it.
- R11: `first_fail_addr` captures the linear address of the first mismatch since reset and keeps it.
- R12: While reset is held, all strobes and `dram_we_n` are high, `tst_busy`, all indicators and `err_count` are 0, and the walk restarts at pattern 0, write pass, address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tst_gnt | input | 1 | Grant from the refresh/wake-up sequencer |
| tst_busy | output | 1 | Access or precharge in progress |
| dram_addr | output | ROW_W | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_din | output | 1 | Data to the memory |
| dram_dout | input | 1 | Data from the memory |
| led_run | output | 1 | Running indicator |
| led_pass | output | 1 | Last read pass clean |
| led_fail | output | 1 | Sticky mismatch indicator |
| err_count | output | ERR_W | Saturating mismatch count |
| first_fail_addr | output | 2*ROW_W | Linear address of first mismatch |

## Verification
The assertions check the strobe protocol on every cycle:
- CAS is only low inside RAS.
- The row-to-column delay is exact, and the precharge meets its minimum.
- Both strobes rise together.
- Write enable and the address stay put while CAS is low.
- An access starts only on a grant, and busy covers the access.
- The fail flag is sticky, and the error count only ever steps up by one.

Only the bench scenarios can show the data behaviour against a memory model:
- the address walk order and pattern values;
- the pattern wrap;
- the pass indicator after clean and faulty patterns;
- first-fail capture and count saturation with injected stuck cells;
- the stall under a withheld grant.

// File: rtl/dramt_pkg.sv
package dramt_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_ROW  = 2'd1,
      PH_COL  = 2'd2,
      PH_PRE  = 2'd3
   } phase_e;

   typedef enum logic [1:0] {
      PAT_ZERO  = 2'd0,
      PAT_ONE   = 2'd1,
      PAT_ALT01 = 2'd2,
      PAT_ALT10 = 2'd3
   } pat_e;

   function automatic logic pat_bit(input pat_e pat, input logic lsb);
      logic b;
      case (pat)
         PAT_ZERO:  b = 1'b0;
         PAT_ONE:   b = 1'b1;
         PAT_ALT01: b = lsb;
         default:   b = ~lsb;
      endcase
      return b;
   endfunction

endpackage

// File: rtl/dramt_strobe_fsm.sv
module dramt_strobe_fsm
   import dramt_pkg::*;
#(
   parameter int T_RCD = 2,
   parameter int T_CAS = 2,
   parameter int T_PRE = 2
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   gnt,
   output phase_e phase,
   output logic   sample_stb,
   output logic   acc_done
);

   localparam int T_MAX = (T_RCD > T_CAS) ? ((T_RCD > T_PRE) ? T_RCD : T_PRE)
                                          : ((T_CAS > T_PRE) ? T_CAS : T_PRE);
   localparam int CNT_W = $clog2(T_MAX + 1);
   localparam logic [CNT_W-1:0] RCD_LAST = CNT_W'(T_RCD - 1);
   localparam logic [CNT_W-1:0] CAS_LAST = CNT_W'(T_CAS - 1);
   localparam logic [CNT_W-1:0] PRE_LAST = CNT_W'(T_PRE - 1);

   phase_e           ph_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q  <= PH_IDLE;
         cnt_q <= '0;
      end else begin
         case (ph_q)
            PH_IDLE: begin
               cnt_q <= '0;
               if (gnt) ph_q <= PH_ROW;
            end
            PH_ROW: begin
               if (cnt_q == RCD_LAST) begin
                  ph_q  <= PH_COL;
                  cnt_q <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            PH_COL: begin
               if (cnt_q == CAS_LAST) begin
                  ph_q  <= PH_PRE;
                  cnt_q <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: begin
               if (cnt_q == PRE_LAST) begin
                  ph_q  <= PH_IDLE;
                  cnt_q <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
         endcase
      end
   end

   assign phase      = ph_q;
   assign sample_stb = (ph_q == PH_COL) && (cnt_q == CAS_LAST);
   assign acc_done   = (ph_q == PH_PRE) && (cnt_q == PRE_LAST);

endmodule

// File: rtl/dramt_walker.sv
module dramt_walker
   import dramt_pkg::*;
#(
   parameter int LIN_W = 18
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   output logic [LIN_W-1:0] lin,
   output logic             wr_pass,
   output pat_e             pat,
   output logic             pass_end
);

   logic [LIN_W-1:0] lin_q;
   logic             wr_q;
   pat_e             pat_q;
   logic             at_last;

   assign at_last = &lin_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lin_q <= '0;
         wr_q  <= 1'b1;
         pat_q <= PAT_ZERO;
      end else if (step) begin
         lin_q <= lin_q + 1'b1;
         if (at_last) begin
            wr_q <= ~wr_q;
            if (!wr_q) pat_q <= pat_e'(pat_q + 2'd1);
         end
      end
   end

   assign lin      = lin_q;
   assign wr_pass  = wr_q;
   assign pat      = pat_q;
   assign pass_end = step && at_last && !wr_q;

endmodule

// File: rtl/dramt_result.sv
module dramt_result #(
   parameter int LIN_W = 18,
   parameter int ERR_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             chk_en,
   input  logic             obs_bit,
   input  logic             exp_bit,
   input  logic [LIN_W-1:0] lin,
   input  logic             pass_end,
   output logic [ERR_W-1:0] err_count,
   output logic [LIN_W-1:0] first_fail,
   output logic             fail,
   output logic             pass
);

   localparam logic [ERR_W-1:0] ERR_MAX = '1;

   logic             miss;
   logic [ERR_W-1:0] err_q;
   logic [LIN_W-1:0] ff_q;
   logic             fail_q;
   logic             bad_q;
   logic             pass_q;

   assign miss = chk_en && (obs_bit != exp_bit);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         err_q  <= '0;
         ff_q   <= '0;
         fail_q <= 1'b0;
         bad_q  <= 1'b0;
         pass_q <= 1'b0;
      end else begin
         if (miss && (err_q != ERR_MAX)) err_q <= err_q + 1'b1;
         if (miss && !fail_q) ff_q <= lin;
         if (miss) fail_q <= 1'b1;
         if (pass_end) begin
            bad_q  <= 1'b0;
            pass_q <= ~bad_q;
         end else if (miss) begin
            bad_q <= 1'b1;
         end
      end
   end

   assign err_count  = err_q;
   assign first_fail = ff_q;
   assign fail       = fail_q;
   assign pass       = pass_q;

endmodule

// File: rtl/dram_pattern_tester.sv
module dram_pattern_tester
   import dramt_pkg::*;
#(
   parameter int ROW_W = 9,
   parameter int T_RCD = 2,
   parameter int T_CAS = 2,
   parameter int T_PRE = 2,
   parameter int ERR_W = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tst_gnt,
   output logic                 tst_busy,
   output logic [ROW_W-1:0]     dram_addr,
   output logic                 dram_ras_n,
   output logic                 dram_cas_n,
   output logic                 dram_we_n,
   output logic                 dram_din,
   input  logic                 dram_dout,
   output logic                 led_run,
   output logic                 led_pass,
   output logic                 led_fail,
   output logic [ERR_W-1:0]     err_count,
   output logic [2*ROW_W-1:0]   first_fail_addr
);

   localparam int LIN_W = 2 * ROW_W;

   initial begin
      assert (ROW_W >= 1) else $error("ROW_W must be at least 1");
      assert (T_RCD >= 1) else $error("T_RCD must be at least 1");
      assert (T_CAS >= 1) else $error("T_CAS must be at least 1");
      assert (T_PRE >= 1) else $error("T_PRE must be at least 1");
      assert (ERR_W >= 1) else $error("ERR_W must be at least 1");
   end

   phase_e           phase;
   logic             sample_stb;
   logic             acc_done;
   logic [LIN_W-1:0] lin;
   logic             wr_pass;
   pat_e             pat;
   logic             pass_end;
   logic             exp_bit;
   logic             ras_act;
   logic             run_q;

   dramt_strobe_fsm #(
      .T_RCD (T_RCD),
      .T_CAS (T_CAS),
      .T_PRE (T_PRE)
   ) u_strobe (
      .clk        (clk),
      .rst_n      (rst_n),
      .gnt        (tst_gnt),
      .phase      (phase),
      .sample_stb (sample_stb),
      .acc_done   (acc_done)
   );

   dramt_walker #(
      .LIN_W (LIN_W)
   ) u_walk (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (acc_done),
      .lin      (lin),
      .wr_pass  (wr_pass),
      .pat      (pat),
      .pass_end (pass_end)
   );

   assign exp_bit = pat_bit(pat, lin[0]);

   dramt_result #(
      .LIN_W (LIN_W),
      .ERR_W (ERR_W)
   ) u_res (
      .clk        (clk),
      .rst_n      (rst_n),
      .chk_en     (sample_stb && !wr_pass),
      .obs_bit    (dram_dout),
      .exp_bit    (exp_bit),
      .lin        (lin),
      .pass_end   (pass_end),
      .err_count  (err_count),
      .first_fail (first_fail_addr),
      .fail       (led_fail),
      .pass       (led_pass)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) run_q <= 1'b0;
      else        run_q <= (phase != PH_IDLE) || tst_gnt;
   end

   assign ras_act    = (phase == PH_ROW) || (phase == PH_COL);
   assign dram_ras_n = ~ras_act;
   assign dram_cas_n = ~(phase == PH_COL);
   assign dram_we_n  = ~(ras_act && wr_pass);
   assign dram_din   = exp_bit;
   assign dram_addr  = (phase == PH_COL) ? lin[ROW_W-1:0] : lin[LIN_W-1 -: ROW_W];
   assign tst_busy   = (phase != PH_IDLE);
   assign led_run    = run_q;

endmodule

// File: rtl/dramt_sva.sv
module dramt_sva #(
   parameter int ROW_W = 9,
   parameter int T_RCD = 2,
   parameter int T_PRE = 2,
   parameter int ERR_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tst_gnt,
   input logic             tst_busy,
   input logic [ROW_W-1:0] dram_addr,
   input logic             dram_ras_n,
   input logic             dram_cas_n,
   input logic             dram_we_n,
   input logic             led_fail,
   input logic [ERR_W-1:0] err_count
);

   logic [15:0] rcd_cnt;
   logic [15:0] pre_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rcd_cnt <= '0;
         pre_cnt <= 16'hFFFF;
      end else begin
         if (dram_ras_n)      rcd_cnt <= '0;
         else if (dram_cas_n) rcd_cnt <= rcd_cnt + 16'd1;
         if (!dram_ras_n)               pre_cnt <= '0;
         else if (pre_cnt != 16'hFFFF)  pre_cnt <= pre_cnt + 16'd1;
      end
   end

   p_cas_in_ras_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !dram_cas_n |-> !dram_ras_n);

   p_ras_to_cas_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dram_cas_n) |-> (rcd_cnt == 16'(T_RCD)));

   p_col_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!dram_cas_n && $past(!dram_cas_n)) |-> $stable(dram_addr));

   p_rise_together_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dram_ras_n) |-> $rose(dram_cas_n));

   p_precharge_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dram_ras_n) |-> (pre_cnt >= 16'(T_PRE)));

   p_we_early_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dram_cas_n) |-> $stable(dram_we_n));

   p_we_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!dram_cas_n && $past(!dram_cas_n)) |-> $stable(dram_we_n));

   p_start_gnt_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dram_ras_n) |-> $past(tst_gnt));

   p_busy_cover_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !dram_ras_n |-> tst_busy);

   p_fail_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      led_fail |=> led_fail);

   p_err_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (err_count != '0) |-> led_fail);

   p_err_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(err_count) |-> (err_count == $past(err_count) + 1'b1));

endmodule

bind dram_pattern_tester dramt_sva #(
   .ROW_W (ROW_W),
   .T_RCD (T_RCD),
   .T_PRE (T_PRE),
   .ERR_W (ERR_W)
) u_sva (
   .clk        (clk),
   .rst_n      (rst_n),
   .tst_gnt    (tst_gnt),
   .tst_busy   (tst_busy),
   .dram_addr  (dram_addr),
   .dram_ras_n (dram_ras_n),
   .dram_cas_n (dram_cas_n),
   .dram_we_n  (dram_we_n),
   .led_fail   (led_fail),
   .err_count  (err_count)
);

// File: tb/dram_pattern_tester_tb.sv
module dram_pattern_tester_tb;

   localparam int ROW_W = 3;
   localparam int LIN_W = 2 * ROW_W;
   localparam int N     = 1 << LIN_W;
   localparam int T_RCD = 2;
   localparam int T_CAS = 2;
   localparam int T_PRE = 3;
   localparam int ERR_W = 4;
   localparam int ERR_MAX = (1 << ERR_W) - 1;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             tst_gnt = 1'b1;
   logic             tst_busy;
   logic [ROW_W-1:0] dram_addr;
   logic             dram_ras_n, dram_cas_n, dram_we_n, dram_din, dram_dout;
   logic             led_run, led_pass, led_fail;
   logic [ERR_W-1:0] err_count;
   logic [LIN_W-1:0] first_fail_addr;

   int  n_checks = 0;
   int  n_fail   = 0;
   bit  done     = 1'b0;
   bit  gnt_rand = 1'b0;

   // memory model and stuck-cell faults
   bit [N-1:0]       mem;
   bit               flt_en = 1'b0;
   logic [LIN_W-1:0] s1_addr = '0;
   logic [LIN_W-1:0] s0_addr = '0;
   logic [ROW_W-1:0] row_l = '0;

   // bus monitor state
   int  acc_k = 0;
   bit  ras_q = 1'b1, cas_q = 1'b1, gnt_q = 1'b1;
   int  rcd_c = 0, cas_c = 0, pre_c = 100;

   always #2 clk = ~clk;

   dram_pattern_tester #(
      .ROW_W (ROW_W), .T_RCD (T_RCD), .T_CAS (T_CAS), .T_PRE (T_PRE), .ERR_W (ERR_W)
   ) u_dut (
      .clk (clk), .rst_n (rst_n), .tst_gnt (tst_gnt), .tst_busy (tst_busy),
      .dram_addr (dram_addr), .dram_ras_n (dram_ras_n), .dram_cas_n (dram_cas_n),
      .dram_we_n (dram_we_n), .dram_din (dram_din), .dram_dout (dram_dout),
      .led_run (led_run), .led_pass (led_pass), .led_fail (led_fail),
      .err_count (err_count), .first_fail_addr (first_fail_addr)
   );

   function automatic bit cell_val(input logic [LIN_W-1:0] a);
      if (flt_en && a == s1_addr) return 1'b1;
      if (flt_en && a == s0_addr) return 1'b0;
      return mem[a];
   endfunction

   assign dram_dout = (!dram_cas_n && dram_we_n) ? cell_val({row_l, dram_addr}) : 1'b0;

   function automatic bit ref_bit(input int p, input int a);
      case (p)
         0: return 1'b0;
         1: return 1'b1;
         2: return a[0];
         default: return ~a[0];
      endcase
   endfunction

   // mismatches one pattern's read pass should produce under the current faults
   function automatic int ref_perr(input int p);
      int e = 0;
      if (flt_en) begin
         if (ref_bit(p, int'(s1_addr)) != 1'b1) e++;
         if (ref_bit(p, int'(s0_addr)) != 1'b0) e++;
      end
      return e;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         acc_k = 0; ras_q = 1'b1; cas_q = 1'b1; gnt_q = tst_gnt;
         rcd_c = 0; cas_c = 0; pre_c = 100;
      end else begin
         if (ras_q && !dram_ras_n) begin
            chk(gnt_q, "R6", "access began without grant", 0, 1);
            chk(pre_c >= T_PRE, "R2", "precharge clocks", pre_c, T_PRE);
            row_l = dram_addr;
            rcd_c = 1;
         end else if (!dram_ras_n && dram_cas_n) begin
            rcd_c++;
         end
         if (cas_q && !dram_cas_n) begin
            int lin, p, m, cum;
            bit wr;
            lin = int'({row_l, dram_addr});
            p   = (acc_k / (2 * N)) % 4;
            wr  = ((acc_k / N) % 2) == 0;
            chk(rcd_c == T_RCD, "R1", "row to column clocks", rcd_c, T_RCD);
            chk(lin == acc_k % N, "R1", "linear address order", lin, acc_k % N);
            chk(dram_we_n == !wr, "R3", "write enable level at CAS fall", dram_we_n, !wr);
            if (wr) begin
               chk(dram_din == ref_bit(p, lin), "R5", "written pattern bit", dram_din, ref_bit(p, lin));
               mem[lin] = dram_din;
            end
            if (acc_k > 0 && acc_k % (2 * N) == 0) begin
               m   = acc_k / (2 * N);
               cum = 0;
               for (int i = 0; i < m; i++) cum += ref_perr(i % 4);
               if (cum > ERR_MAX) cum = ERR_MAX;
               chk(led_pass == (ref_perr((m - 1) % 4) == 0), "R8", "pass indicator",
                   led_pass, ref_perr((m - 1) % 4) == 0);
               chk(int'(err_count) == cum, "R10", "running error count", err_count, cum);
            end
            acc_k++;
            cas_c = 1;
         end else if (!dram_cas_n) begin
            cas_c++;
         end
         if (!ras_q && dram_ras_n) begin
            chk(dram_cas_n == 1'b1, "R2", "CAS rises with RAS", dram_cas_n, 1);
            chk(cas_c == T_CAS, "R2", "CAS low clocks", cas_c, T_CAS);
            pre_c = 1;
         end else if (dram_ras_n) begin
            pre_c++;
         end
         ras_q = dram_ras_n; cas_q = dram_cas_n; gnt_q = tst_gnt;
      end
   end

   // random grant withdrawal, as a refresh sequencer would do
   initial begin
      forever begin
         @(negedge clk);
         if (gnt_rand) tst_gnt = ($urandom % 4) != 0;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", acc_k, -1);
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      int k0;
      void'($urandom(32'h5EED_1234));
      // R12 reset state
      repeat (4) @(negedge clk);
      chk(dram_ras_n && dram_cas_n && dram_we_n, "R12", "strobes idle in reset", {dram_ras_n, dram_cas_n, dram_we_n}, 7);
      chk(!tst_busy && !led_run && !led_pass && !led_fail, "R12", "busy and indicators in reset",
          {tst_busy, led_run, led_pass, led_fail}, 0);
      chk(err_count == 0, "R12", "error count in reset", err_count, 0);
      @(negedge clk) rst_n = 1'b1;

      // clean loop with random grant, through the pattern wrap (R5, R4)
      gnt_rand = 1'b1;
      wait (acc_k >= 8 * N + 2);
      @(negedge clk);
      chk(err_count == 0, "R4", "no mismatch on clean memory", err_count, 0);
      chk(!led_fail, "R9", "fail stays low on clean memory", led_fail, 0);
      chk(led_pass, "R8", "pass after clean pattern", led_pass, 1);

      // R7 / R6 stall while the grant is held low
      gnt_rand = 1'b0;
      tst_gnt  = 1'b0;
      repeat (30) @(negedge clk);
      k0 = acc_k;
      chk(!led_run, "R7", "run low while stalled", led_run, 0);
      chk(!tst_busy && dram_ras_n, "R6", "no access while grant low", {tst_busy, dram_ras_n}, 1);
      repeat (20) @(negedge clk);
      chk(acc_k == k0, "R6", "access count frozen without grant", acc_k, k0);
      tst_gnt = 1'b1;
      repeat (2) @(negedge clk);
      chk(led_run, "R7", "run high after grant returns", led_run, 1);

      // faulty memory: one cell stuck at 1 (odd address), one stuck at 0 (even)
      rst_n = 1'b0;
      s1_addr = LIN_W'($urandom % N) | LIN_W'(1);
      s0_addr = LIN_W'($urandom % N) & ~LIN_W'(1);
      flt_en  = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      gnt_rand = 1'b1;
      wait (acc_k >= 2 * N + 1);
      @(negedge clk);
      chk(led_fail, "R9", "fail set after stuck-at-1 read", led_fail, 1);
      chk(first_fail_addr == s1_addr, "R11", "first failing address", first_fail_addr, s1_addr);
      wait (acc_k >= 32 * N + 1);
      @(negedge clk);
      chk(err_count == ERR_W'(ERR_MAX), "R10", "count saturates", err_count, ERR_MAX);
      chk(first_fail_addr == s1_addr, "R11", "first failing address kept", first_fail_addr, s1_addr);
      chk(led_fail, "R9", "fail still latched", led_fail, 1);

      // reset clears the latched state
      gnt_rand = 1'b0;
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      chk(!led_fail && err_count == 0, "R9", "reset clears fail and count", {led_fail, err_count}, 0);
      chk(!led_pass && !tst_busy, "R12", "reset clears pass and busy", {led_pass, tst_busy}, 0);

      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

endmodule